// File: doc/BRIEF.md
# Script Branch Condition Evaluator

This block sits beside the instruction decoder of a small bus-protocol script engine. When the engine issues a transfer-control instruction, the block decides whether the branch or interrupt fires. It works from the instruction's control bits, the bus phase captured on the request strobe, the first data byte received, the attention line, the carry flag and the initiator/target mode. It returns a one-cycle decision strobe with the take/no-take result. Interrupt instructions also get a halt request, or a sticky status flag for the non-halting variant.

A state machine with three states drives the block:
- `ST_IDLE` waits for `start` and captures the instruction word. It moves to `ST_WAIT` when the wait-for-phase bit is set, and to `ST_EVAL` otherwise.
- `ST_WAIT` holds until `phase_valid` strobes in a new phase, then moves to `ST_EVAL`.
- `ST_EVAL` forms the condition, registers the decision and returns to `ST_IDLE`.

The phase register loads `bus_phase` on every `phase_valid`, in any state.

Instruction word layout:

| Bits  | Meaning                     |
|-------|-----------------------------|
| 7:0   | data field                  |
| 16    | wait for valid phase        |
| 17    | compare phase               |
| 18    | compare data                |
| 19    | polarity                    |
| 20    | on-the-fly                  |
| 21    | carry test                  |
| 22    | interrupt instruction       |
| 26:24 | phase field                 |

Top module: `brcond_eval`

## Requirements
- R1: After reset, `done`, `take`, `halt` and `irq_flag` are all 0 and the machine is idle.
- R2: For an instruction with bit 16 clear, `done` is high for exactly one cycle, one clock edge after the edge that samples `start`. `take` and `halt` are only ever high together with `done`.
- R3: With only bit 18 (compare data) set, the data term is true when `first_byte` equals bits 7:0. The branch is taken when the term is true and bit 19 is 1, or when the term is false and bit 19 is 0.
- R4: In initiator mode (`target_mode`=0), bit 17 makes the phase term true when the last phase latched by `phase_valid` equals bits 26:24.
- R5: In target mode (`target_mode`=1), bit 17 makes the phase term equal to `atn`, regardless of the latched phase.
- R6: With bits 17 and 18 both set, polarity 1 takes the branch only when both terms are true, and polarity 0 only when both are false. When one term is true and the other false, the branch is not taken under either polarity.
- R7: With bit 21 set, `carry` is the only tested term and bits 17 and 18 are ignored. The branch is taken when carry equals bit 19.
- R8: With bits 17, 18 and 21 all clear, the condition counts as true, so `take` equals bit 19.
- R9: With bit 16 set, no decision is made until `phase_valid` is sampled. `done` follows one edge after that, and the compare uses the newly latched phase.
- R10: For an interrupt instruction (bit 22 set, bit 20 clear), `halt` goes high together with `done` when the branch is taken, and stays low when it is not.
- R11: For an interrupt instruction with bit 20 set, a taken branch leaves `halt` low and sets `irq_flag` in the same cycle as `done`. The flag then stays set.
- R12: `flag_clr` clears `irq_flag` on the next edge. If a new on-the-fly set lands in the same cycle, the set wins.
- R13: A `start` that arrives while a decision is pending is ignored, so only the first instruction produces a `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue strobe for `insn` |
| insn | input | INSN_W | Transfer-control instruction word |
| phase_valid | input | 1 | Request strobe; latches `bus_phase` |
| bus_phase | input | PHASE_W | Bus phase lines |
| first_byte | input | DATA_W | First byte received from the bus |
| atn | input | 1 | Attention line (target mode test) |
| carry | input | 1 | Carry flag |
| target_mode | input | 1 | 1 = target, 0 = initiator |
| flag_clr | input | 1 | Write-one clear of the status flag |
| done | output | 1 | Decision strobe |
| take | output | 1 | Branch taken, valid with `done` |
| halt | output | 1 | Halt request for a taken halting interrupt |
| irq_flag | output | 1 | Sticky on-the-fly interrupt flag |

## Verification
The bench goes after the mixed case in which one compare matches and the other does not. A design that ORs the terms, or that inverts a single combined result, would branch there under one of the two polarities. It checks that carry tests override the compare bits and that target mode looks at `atn` rather than a stale latched phase; a design that gets either wrong branches on the wrong input. The bench also lands a flag clear in the same cycle as a new on-the-fly event, which a clear-first design would lose. Finally, it issues a second `start` during a phase wait, which would otherwise replace the pending instruction or produce a second decision.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_EVAL
    } st_t;

    // Control-bit positions in the instruction word
    localparam int B_WAIT  = 16;
    localparam int B_CPH   = 17;
    localparam int B_CDAT  = 18;
    localparam int B_POL   = 19;
    localparam int B_ONFLY = 20;
    localparam int B_CARRY = 21;
    localparam int B_IRQ   = 22;
    localparam int PH_LSB  = 24;
    localparam int DAT_LSB = 0;

    typedef struct packed {
        logic pol;
        logic cmp_data;
        logic cmp_phase;
        logic wait_ph;
        logic carry_t;
        logic irq;
        logic on_fly;
    } ctl_t;

endpackage

// File: rtl/brcond_cmp.sv
module brcond_cmp
    import brcond_pkg::*;
#(
    parameter int PHASE_W = 3,
    parameter int DATA_W  = 8
) (
    input  ctl_t               ctl,
    input  logic [PHASE_W-1:0] phase_q,
    input  logic [PHASE_W-1:0] f_phase,
    input  logic [DATA_W-1:0]  rx_byte,
    input  logic [DATA_W-1:0]  f_data,
    input  logic               atn,
    input  logic               carry,
    input  logic               target_mode,
    output logic               hit
);
    localparam int N_TERM = 2;

    logic [N_TERM-1:0] en;
    logic [N_TERM-1:0] ok;

    // term 0: phase / attention, term 1: data byte
    assign en[0] = ctl.cmp_phase;
    assign ok[0] = target_mode ? atn : (phase_q == f_phase);
    assign en[1] = ctl.cmp_data;
    assign ok[1] = (rx_byte == f_data);

    always_comb begin
        if (ctl.carry_t) begin
            hit = (carry == ctl.pol);
        end else if (en == '0) begin
            hit = ctl.pol;
        end else if (ctl.pol) begin
            hit = ((ok & en) == en);
        end else begin
            hit = ((ok & en) == '0);
        end
    end

endmodule

// File: rtl/brcond_flag.sv
module brcond_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_i) begin
            flag <= 1'b1;
        end else if (clr_i) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
    import brcond_pkg::*;
#(
    parameter int INSN_W  = 32,
    parameter int PHASE_W = 3,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSN_W-1:0]  insn,
    input  logic               phase_valid,
    input  logic [PHASE_W-1:0] bus_phase,
    input  logic [DATA_W-1:0]  first_byte,
    input  logic               atn,
    input  logic               carry,
    input  logic               target_mode,
    input  logic               flag_clr,
    output logic               done,
    output logic               take,
    output logic               halt,
    output logic               irq_flag
);
    localparam int PH_MSB = PH_LSB + PHASE_W - 1;

    st_t                state, state_nx;
    logic [INSN_W-1:0]  insn_q;
    logic [PHASE_W-1:0] phase_q;
    ctl_t               ctl;
    logic               hit;
    logic               in_eval;
    logic               fly_set;

    assign ctl.pol       = insn_q[B_POL];
    assign ctl.cmp_data  = insn_q[B_CDAT];
    assign ctl.cmp_phase = insn_q[B_CPH];
    assign ctl.wait_ph   = insn_q[B_WAIT];
    assign ctl.carry_t   = insn_q[B_CARRY];
    assign ctl.irq       = insn_q[B_IRQ];
    assign ctl.on_fly    = insn_q[B_ONFLY];

    assign in_eval = (state == ST_EVAL);
    assign fly_set = in_eval && ctl.irq && ctl.on_fly && hit;

    brcond_cmp #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) u_cmp (
        .ctl        (ctl),
        .phase_q    (phase_q),
        .f_phase    (insn_q[PH_MSB:PH_LSB]),
        .rx_byte    (first_byte),
        .f_data     (insn_q[DAT_LSB +: DATA_W]),
        .atn        (atn),
        .carry      (carry),
        .target_mode(target_mode),
        .hit        (hit)
    );

    brcond_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(fly_set),
        .clr_i(flag_clr),
        .flag (irq_flag)
    );

    // Phase latch on the request strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_valid) begin
            phase_q <= bus_phase;
        end
    end

    // Instruction capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insn_q <= '0;
        end else if (state == ST_IDLE && start) begin
            insn_q <= insn;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = insn[B_WAIT] ? ST_WAIT : ST_EVAL;
            ST_WAIT: if (phase_valid) state_nx = ST_EVAL;
            ST_EVAL: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            take <= 1'b0;
            halt <= 1'b0;
        end else begin
            done <= in_eval;
            take <= in_eval && hit;
            halt <= in_eval && hit && ctl.irq && !ctl.on_fly;
        end
    end

endmodule

// File: rtl/brcond_chk.sv
module brcond_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic take,
    input logic halt,
    input logic irq_flag,
    input logic flag_clr
);
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_take_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> done);

    p_halt_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (take && done));

    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

    p_flag_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> (done && take && !halt));

    p_flag_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> $past(flag_clr));
endmodule

bind brcond_eval brcond_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .take    (take),
    .halt    (halt),
    .irq_flag(irq_flag),
    .flag_clr(flag_clr)
);

// File: tb/brcond_eval_tb.sv
module brcond_eval_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic        phase_valid = 1'b0;
    logic [2:0]  bus_phase = '0;
    logic [7:0]  first_byte = '0;
    logic        atn = 1'b0;
    logic        carry = 1'b0;
    logic        target_mode = 1'b0;
    logic        flag_clr = 1'b0;
    logic        done, take, halt, irq_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    brcond_eval u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
        .phase_valid(phase_valid), .bus_phase(bus_phase),
        .first_byte(first_byte), .atn(atn), .carry(carry),
        .target_mode(target_mode), .flag_clr(flag_clr),
        .done(done), .take(take), .halt(halt), .irq_flag(irq_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit pol, bit cd, bit cp, bit wt, bit cy,
                                       bit irq, bit fly, logic [2:0] ph, logic [7:0] d);
        logic [31:0] w = '0;
        w[19] = pol; w[18] = cd; w[17] = cp; w[16] = wt;
        w[21] = cy;  w[22] = irq; w[20] = fly;
        w[26:24] = ph; w[7:0] = d;
        return w;
    endfunction

    // Called at a negedge; returns at the negedge where done is seen
    task automatic run(input logic [31:0] w, output int lat, output bit tk, output bit hk);
        insn = w; start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk); lat++;
        end
        tk = take; hk = halt;
    endtask

    task automatic latch_phase(input logic [2:0] ph);
        bus_phase = ph; phase_valid = 1'b1;
        @(negedge clk); phase_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 done", done, 0);
        check("R1 take", take, 0);
        check("R1 halt", halt, 0);
        check("R1 flag", irq_flag, 0);
    endtask

    task automatic t_data;
        int lat; bit tk, hk;
        first_byte = 8'h5A;
        run(mk(1,1,0,0,0,0,0,0,8'h5A), lat, tk, hk);
        check("R2 latency", lat, 2);
        check("R3 pol1 match", tk, 1);
        @(negedge clk);
        check("R2 done one cycle", done, 0);
        run(mk(1,1,0,0,0,0,0,0,8'h5B), lat, tk, hk);
        check("R3 pol1 mismatch", tk, 0);
        run(mk(0,1,0,0,0,0,0,0,8'h5B), lat, tk, hk);
        check("R3 pol0 mismatch", tk, 1);
        run(mk(0,1,0,0,0,0,0,0,8'h5A), lat, tk, hk);
        check("R3 pol0 match", tk, 0);
    endtask

    task automatic t_phase;
        int lat; bit tk, hk;
        target_mode = 1'b0;
        latch_phase(3'd6);
        bus_phase = 3'd1;
        run(mk(1,0,1,0,0,0,0,3'd6,0), lat, tk, hk);
        check("R4 latched phase match", tk, 1);
        run(mk(1,0,1,0,0,0,0,3'd1,0), lat, tk, hk);
        check("R4 live lines not latched", tk, 0);
    endtask

    task automatic t_target;
        int lat; bit tk, hk;
        target_mode = 1'b1;
        latch_phase(3'd3);
        atn = 1'b1;
        run(mk(1,0,1,0,0,0,0,3'd0,0), lat, tk, hk);
        check("R5 atn high", tk, 1);
        atn = 1'b0;
        run(mk(1,0,1,0,0,0,0,3'd3,0), lat, tk, hk);
        check("R5 atn low phase ignored", tk, 0);
        target_mode = 1'b0;
    endtask

    task automatic t_both;
        int lat; bit tk, hk;
        latch_phase(3'd2);
        first_byte = 8'hC3;
        run(mk(1,1,1,0,0,0,0,3'd2,8'hC3), lat, tk, hk);
        check("R6 pol1 both match", tk, 1);
        run(mk(1,1,1,0,0,0,0,3'd2,8'h00), lat, tk, hk);
        check("R6 pol1 mixed", tk, 0);
        run(mk(0,1,1,0,0,0,0,3'd2,8'h00), lat, tk, hk);
        check("R6 pol0 mixed", tk, 0);
        run(mk(0,1,1,0,0,0,0,3'd5,8'h00), lat, tk, hk);
        check("R6 pol0 both mismatch", tk, 1);
    endtask

    task automatic t_carry;
        int lat; bit tk, hk;
        latch_phase(3'd0);
        first_byte = 8'h11;
        carry = 1'b1;
        run(mk(1,1,1,0,1,0,0,3'd7,8'h22), lat, tk, hk);
        check("R7 pol1 carry1 compares ignored", tk, 1);
        carry = 1'b0;
        run(mk(1,1,1,0,1,0,0,3'd0,8'h11), lat, tk, hk);
        check("R7 pol1 carry0", tk, 0);
        run(mk(0,0,0,0,1,0,0,0,0), lat, tk, hk);
        check("R7 pol0 carry0", tk, 1);
    endtask

    task automatic t_uncond;
        int lat; bit tk, hk;
        run(mk(1,0,0,0,0,0,0,0,0), lat, tk, hk);
        check("R8 pol1 unconditional", tk, 1);
        run(mk(0,0,0,0,0,0,0,0,0), lat, tk, hk);
        check("R8 pol0 never", tk, 0);
    endtask

    task automatic t_wait;
        int lat; bit tk, hk;
        latch_phase(3'd1);
        insn = mk(1,0,1,1,0,0,0,3'd4,0); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 no decision before phase", done, 0);
        latch_phase(3'd4);
        check("R9 not yet", done, 0);
        @(negedge clk);
        check("R9 done after phase", done, 1);
        check("R9 uses new phase", take, 1);
    endtask

    task automatic t_irq;
        int lat; bit tk, hk;
        run(mk(1,0,0,0,0,1,0,0,0), lat, tk, hk);
        check("R10 halt when taken", hk, 1);
        check("R10 no flag", irq_flag, 0);
        run(mk(0,0,0,0,0,1,0,0,0), lat, tk, hk);
        check("R10 no halt when not taken", hk, 0);
    endtask

    task automatic t_onfly;
        int lat; bit tk, hk;
        run(mk(1,0,0,0,0,1,1,0,0), lat, tk, hk);
        check("R11 no halt", hk, 0);
        check("R11 flag with done", irq_flag, 1);
        repeat (3) @(negedge clk);
        check("R11 sticky", irq_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R12 cleared", irq_flag, 0);
        // set and clear land on the same edge
        insn = mk(1,0,0,0,0,1,1,0,0); start = 1'b1;
        @(negedge clk); start = 1'b0; flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R12 done", done, 1);
        check("R12 set beats clear", irq_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic t_busy;
        int seen = 0;
        first_byte = 8'h77;
        insn = mk(1,1,0,1,0,0,0,0,8'h77); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        insn = mk(0,0,0,0,0,0,0,0,0); start = 1'b1;
        @(negedge clk); start = 1'b0;
        latch_phase(3'd2);
        @(negedge clk);
        check("R13 first done", done, 1);
        check("R13 first result kept", take, 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (done) seen++;
        end
        check("R13 no second done", seen, 0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data();
        t_phase();
        t_target();
        t_both();
        t_carry();
        t_uncond();
        t_wait();
        t_irq();
        t_onfly();
        t_busy();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule